// File: doc/BRIEF.md
# Step Burst Generator

The step burst generator is one channel mode of a timer that drives stepper-motor power stages. Software writes a start value and an end value, then strobes start. From then on the channel advances its counter once for every asserted count-enable cycle. Each advance also appears as a one-cycle high pulse on the output. The output therefore follows the chosen count rate. When the counter arrives at the end value, the channel halts itself. The drive sees exactly (end minus start) steps.

The burst only runs under one combination of settings: the count-mode field selects the pulse mode, the output-mode field selects gated-clock output, and one-shot operation is set. It also needs a count rate slower than the undivided system clock. When any of these is missing, a start request is dropped and no pulse is produced. The start and end values are captured when a burst is accepted. Writes made during a burst therefore cannot stretch or cut it. A burst whose end value does not exceed its start value completes immediately and produces no pulses.

Top module: `step_burst_gen`

## Requirements
- R1: During and right after reset, `busy_o` is 0, `pulse_o` is 0 and `count_o` is 0.
- R2: A start is accepted only when `cnt_mode_i` is 3'b001, `out_mode_i` is 4'b1111, `one_shot_i` is 1 and `src_sysclk_i` is 0. Under any other setting the start is ignored: `busy_o` stays 0 and no pulse appears.
- R3: An accepted start makes `busy_o` high at the next clock edge and sets `count_o` to the `load_val_i` value present with the strobe.
- R4: In each cycle with `busy_o` high, `cnt_en_i` high and the count below the captured end value, `count_o` rises by one at the next edge and `pulse_o` is high for exactly that following cycle. A busy cycle with `cnt_en_i` low holds the count and gives no pulse.
- R5: A burst gives exactly (end − start) pulses. `busy_o` falls at the same edge where the last pulse rises.
- R6: If the end value is less than or equal to the start value, no pulse occurs and `busy_o` is high for exactly one cycle.
- R7: A start strobe while `busy_o` is high is ignored, including a strobe in the cycle of the final step. The count sequence and pulse total are unchanged.
- R8: Changes on `load_val_i` and `cmp_val_i` while busy have no effect on the running burst.
- R9: If the mode settings stop qualifying during a burst, `busy_o` clears at the next edge, no further pulse is produced and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a burst |
| cnt_en_i | input | 1 | Count-rate enable, one step per high cycle |
| cnt_mode_i | input | 3 | Count-mode field, 3'b001 selects pulse mode |
| out_mode_i | input | 4 | Output-mode field, 4'b1111 selects gated-clock output |
| one_shot_i | input | 1 | One-shot operation enable |
| src_sysclk_i | input | 1 | High when the count rate is the undivided system clock |
| load_val_i | input | CNT_W | Start value of the counter |
| cmp_val_i | input | CNT_W | End value of the counter |
| busy_o | output | 1 | Burst in progress |
| pulse_o | output | 1 | Registered step pulse output |
| count_o | output | CNT_W | Current counter value |

## Verification
Two events can land in the same edge. One is the final count step, which both emits the last pulse and ends the burst. The other is a fresh start strobe. The bench times a strobe to the cycle where the count sits one below the end value. It judges the result against a behavioural model: busy must drop, the count must stop at the end value, and no reload may occur. A second collision occurs when the mode settings are withdrawn during a running burst. That must end the burst without a further pulse.

// File: rtl/step_burst_pkg.sv
package step_burst_pkg;
  localparam logic [2:0] SB_CNT_MODE_PULSE = 3'b001;
  localparam logic [3:0] SB_OUT_MODE_GATED = 4'b1111;

  typedef enum logic {
    SB_IDLE = 1'b0,
    SB_RUN  = 1'b1
  } sb_state_e;
endpackage

// File: rtl/sbg_mode_qual.sv
module sbg_mode_qual
  import step_burst_pkg::*;
(
  input  logic [2:0] cnt_mode_i,
  input  logic [3:0] out_mode_i,
  input  logic       one_shot_i,
  input  logic       src_sysclk_i,
  output logic       mode_ok_o
);
  logic cnt_sel;
  logic out_sel;

  always_comb begin
    cnt_sel   = (cnt_mode_i == SB_CNT_MODE_PULSE);
    out_sel   = (out_mode_i == SB_OUT_MODE_GATED);
    // R2: undivided system clock cannot be gated through, so it blocks the mode
    mode_ok_o = cnt_sel && out_sel && one_shot_i && !src_sysclk_i;
  end
endmodule

// File: rtl/sbg_counter.sv
module sbg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             remaining_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + ONE;
    cnt_d   = cnt_q;
    cmp_d   = cmp_q;
    if (load_i) begin
      // R8: both bounds captured only on an accepted start
      cnt_d = load_val_i;
      cmp_d = cmp_val_i;
    end else if (inc_i) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
    end
  end

  always_comb begin
    count_o     = cnt_q;
    remaining_o = (cnt_q < cmp_q);
    last_o      = (cnt_inc == cmp_q);
  end
endmodule

// File: rtl/sbg_seq.sv
module sbg_seq
  import step_burst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mode_ok_i,
  input  logic remaining_i,
  input  logic last_step_i,
  output logic accept_o,
  output logic busy_o
);
  sb_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    unique case (state_q)
      SB_IDLE: begin
        if (start_i && mode_ok_i) begin
          accept_o = 1'b1;
          state_d  = SB_RUN;
        end
      end
      SB_RUN: begin
        // R7: start_i is not looked at while running
        if (!mode_ok_i || !remaining_i || last_step_i) begin
          state_d = SB_IDLE;
        end
      end
      default: state_d = SB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SB_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy_o = (state_q == SB_RUN);
endmodule

// File: rtl/sbg_out_reg.sv
module sbg_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_d_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d_i;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/step_burst_gen.sv
module step_burst_gen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cnt_en_i,
  input  logic [2:0]       cnt_mode_i,
  input  logic [3:0]       out_mode_i,
  input  logic             one_shot_i,
  input  logic             src_sysclk_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic             busy_o,
  output logic             pulse_o,
  output logic [CNT_W-1:0] count_o
);
  logic mode_ok;
  logic accept;
  logic busy;
  logic remaining;
  logic last_pos;
  logic step;
  logic last_step;

  sbg_mode_qual u_qual (
    .cnt_mode_i   (cnt_mode_i),
    .out_mode_i   (out_mode_i),
    .one_shot_i   (one_shot_i),
    .src_sysclk_i (src_sysclk_i),
    .mode_ok_o    (mode_ok)
  );

  // R4: one step per enabled busy cycle while below the end value
  always_comb begin
    step      = busy && mode_ok && cnt_en_i && remaining;
    last_step = step && last_pos;
  end

  sbg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .load_val_i  (load_val_i),
    .cmp_val_i   (cmp_val_i),
    .inc_i       (step),
    .count_o     (count_o),
    .remaining_o (remaining),
    .last_o      (last_pos)
  );

  sbg_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_ok_i   (mode_ok),
    .remaining_i (remaining),
    .last_step_i (last_step),
    .accept_o    (accept),
    .busy_o      (busy)
  );

  sbg_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_d_i (step),
    .pulse_o   (pulse_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker
  import step_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cnt_en_i,
  input logic [2:0]       cnt_mode_i,
  input logic [3:0]       out_mode_i,
  input logic             one_shot_i,
  input logic             src_sysclk_i,
  input logic             busy_o,
  input logic             pulse_o,
  input logic [CNT_W-1:0] count_o
);
  logic chk_mode_ok;
  assign chk_mode_ok = (cnt_mode_i == SB_CNT_MODE_PULSE) && (out_mode_i == SB_OUT_MODE_GATED)
                       && one_shot_i && !src_sysclk_i;

  a_r4_pulse_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(busy_o));

  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (count_o == CNT_W'($past(count_o) + 1'b1)));

  a_r7_start_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !cnt_en_i) |=> $stable(count_o));

  a_r2_unqualified_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_mode_ok |=> !pulse_o);

  a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o);

  a_r9_drop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !chk_mode_ok) |=> !busy_o);
endmodule

bind step_burst_gen sbg_checker #(.CNT_W(CNT_W)) u_sbg_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .cnt_en_i     (cnt_en_i),
  .cnt_mode_i   (cnt_mode_i),
  .out_mode_i   (out_mode_i),
  .one_shot_i   (one_shot_i),
  .src_sysclk_i (src_sysclk_i),
  .busy_o       (busy_o),
  .pulse_o      (pulse_o),
  .count_o      (count_o)
);

// File: tb/step_burst_gen_bench.sv
`timescale 1ns/1ps
module step_burst_gen_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         cnt_en_i = 1'b0;
  logic [2:0]   cnt_mode_i = 3'b001;
  logic [3:0]   out_mode_i = 4'b1111;
  logic         one_shot_i = 1'b1;
  logic         src_sysclk_i = 1'b0;
  logic [W-1:0] load_val_i = '0;
  logic [W-1:0] cmp_val_i = '0;
  logic         busy_o;
  logic         pulse_o;
  logic [W-1:0] count_o;

  int tests = 0;
  int fails = 0;
  int pulse_seen = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_busy, m_pulse, m_cnt, m_cmp;

  always #5 clk = ~clk;

  step_burst_gen #(.CNT_W(W)) u_step_burst_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cnt_en_i(cnt_en_i),
    .cnt_mode_i(cnt_mode_i), .out_mode_i(out_mode_i), .one_shot_i(one_shot_i),
    .src_sysclk_i(src_sysclk_i), .load_val_i(load_val_i), .cmp_val_i(cmp_val_i),
    .busy_o(busy_o), .pulse_o(pulse_o), .count_o(count_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_pulse = 0; m_cnt = 0; m_cmp = 0;
    end else begin
      bit ok;
      ok = (cnt_mode_i == 3'b001) && (out_mode_i == 4'b1111) && one_shot_i && !src_sysclk_i;
      m_pulse = 0;
      if (m_busy == 0) begin
        if (start_i && ok) begin
          m_busy = 1; m_cnt = int'(load_val_i); m_cmp = int'(cmp_val_i);
        end
      end else if (!ok || m_cnt >= m_cmp) begin
        m_busy = 0;
      end else if (cnt_en_i) begin
        m_cnt = m_cnt + 1;
        m_pulse = 1;
        if (m_cnt == m_cmp) m_busy = 0;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "busy vs model", int'(busy_o), m_busy);
      chk(cur_req, "pulse vs model", int'(pulse_o), m_pulse);
      chk(cur_req, "count vs model", int'(count_o), m_cnt);
      if (pulse_o) pulse_seen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    start_i = 1'b1;
    tick(1);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) tick(1);
    tick(2);
  endtask

  task automatic run_burst(string req, int ld, int cp, int en_period);
    cur_req = req;
    pulse_seen = 0;
    load_val_i = W'(ld); cmp_val_i = W'(cp);
    strobe();
    for (int i = 0; i < 200 && busy_o; i++) begin
      cnt_en_i = (en_period <= 1) ? 1'b1 : ((i % en_period) == 0);
      tick(1);
    end
    cnt_en_i = 1'b0;
    tick(2);
    chk(req, "pulse total", pulse_seen, (cp > ld) ? cp - ld : 0);
  endtask

  initial begin
    tick(2);
    chk("R1", "busy in reset", int'(busy_o), 0);
    chk("R1", "pulse in reset", int'(pulse_o), 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1", "count after reset", int'(count_o), 0);
    chk("R1", "busy after reset", int'(busy_o), 0);

    // R5: four-step example
    cnt_en_i = 1'b1;
    run_burst("R5", 0, 4, 1);
    chk("R5", "final count", int'(count_o), 4);

    // R4: sparse enable
    run_burst("R4", 10, 17, 3);
    chk("R4", "final count", int'(count_o), 17);

    // R3 / R6: equal and reversed bounds
    cur_req = "R6"; pulse_seen = 0;
    load_val_i = 16'd5; cmp_val_i = 16'd5; cnt_en_i = 1'b1;
    strobe();
    chk("R3", "busy after start", int'(busy_o), 1);
    chk("R3", "count loaded", int'(count_o), 5);
    tick(1);
    chk("R6", "busy one cycle", int'(busy_o), 0);
    tick(2);
    chk("R6", "no pulses equal", pulse_seen, 0);
    run_burst("R6", 9, 2, 1);

    // R2: each disqualifying setting
    for (int k = 0; k < 4; k++) begin
      cur_req = "R2"; pulse_seen = 0;
      cnt_mode_i = (k == 0) ? 3'b010 : 3'b001;
      out_mode_i = (k == 1) ? 4'b1110 : 4'b1111;
      one_shot_i = (k == 2) ? 1'b0 : 1'b1;
      src_sysclk_i = (k == 3);
      load_val_i = 16'd0; cmp_val_i = 16'd6; cnt_en_i = 1'b1;
      strobe();
      tick(4);
      chk("R2", "busy stays low", int'(busy_o), 0);
      chk("R2", "no pulses", pulse_seen, 0);
    end
    cnt_mode_i = 3'b001; out_mode_i = 4'b1111; one_shot_i = 1'b1; src_sysclk_i = 1'b0;

    // R7: strobe while busy, timed onto the final step
    cur_req = "R7"; pulse_seen = 0;
    load_val_i = 16'd0; cmp_val_i = 16'd3; cnt_en_i = 1'b1;
    strobe();
    load_val_i = 16'd40; cmp_val_i = 16'd60;
    tick(1);
    strobe();                 // mid-burst strobe
    strobe();                 // strobe on the final step edge
    chk("R7", "busy after final", int'(busy_o), 0);
    chk("R7", "count not reloaded", int'(count_o), 3);
    tick(2);
    chk("R7", "pulse total", pulse_seen, 3);

    // R8: bounds changed mid-burst
    cur_req = "R8"; pulse_seen = 0;
    load_val_i = 16'd2; cmp_val_i = 16'd8; cnt_en_i = 1'b1;
    strobe();
    load_val_i = 16'd0; cmp_val_i = 16'd3;
    tick(1);
    cmp_val_i = 16'd100;
    wait_idle();
    chk("R8", "pulse total", pulse_seen, 6);
    chk("R8", "final count", int'(count_o), 8);

    // R9: mode withdrawn mid-burst
    cur_req = "R9"; pulse_seen = 0;
    load_val_i = 16'd0; cmp_val_i = 16'd10; cnt_en_i = 1'b1;
    strobe();
    tick(3);
    one_shot_i = 1'b0;
    tick(1);
    chk("R9", "busy cleared", int'(busy_o), 0);
    tick(3);
    chk("R9", "pulses stopped", pulse_seen, 3);
    chk("R9", "count held", int'(count_o), 3);
    one_shot_i = 1'b1;
    cnt_en_i = 1'b0;
    tick(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule